// File: doc/BRIEF.md
# Windowed Register File

This block is a register file for a processor whose procedure calls switch register context without copying anything. Its physical registers are arranged as a ring of overlapping windows, and only one window is visible at a time. A current window pointer selects that window. Each 5-bit architectural register number resolves to one of four groups:

- a bank of globals, shared by every window;
- the outgoing-argument registers of the current window;
- the private locals of the current window;
- the incoming-argument registers, which are the same physical registers as the outgoing-argument registers of the caller window.

A call (save) moves the pointer down by one and a return (restore) moves it up by one, modulo the ring size. Whatever a caller left in its outgoing registers therefore appears in the callee's incoming registers. A count of resident caller windows is kept. From it the block reports overflow when a call finds every window but one in use, and underflow when a return finds no caller window resident. In both cases the pointer is held, so that a separate spill or fill engine can act and the instruction can then be retried.

The file has two combinational read ports and one write port. A read that addresses the physical register being written in the same cycle returns the new value.

Top module: `reg_window_file`

## Requirements
- R1: After reset the window pointer is 0, both flags are low, and no caller window is resident.
- R2: Architectural indices 1 to 7 are globals that reach the same physical register for every pointer value.
- R3: Index 0 always reads as zero, and a write to it leaves every readable register unchanged.
- R4: Indices 8-15 are the current window's outgoing registers (offset index-8) and indices 16-23 are its locals (offset index-16). A window's locals are never reachable from any other window.
- R5: A save asserted alone and not overflowing sets the pointer to (pointer-1) mod 8 and adds one resident window. The callee's index 24+k then reads what the caller wrote to index 8+k.
- R6: A restore asserted alone and not underflowing sets the pointer to (pointer+1) mod 8 and removes one resident window. A value the callee wrote to index 24+k then reads back at the caller's index 8+k.
- R7: A save asserted alone while 6 caller windows are resident raises overflow_o in that same cycle, and the pointer and the count stay unchanged.
- R8: A restore asserted alone while no caller window is resident raises underflow_o in that same cycle, and the pointer stays unchanged.
- R9: Save and restore asserted together have no effect on the pointer or the count, and both flags stay low.
- R10: A write in the same cycle as a save or restore goes to the window that was current before the pointer moves.
- R11: Reads are combinational. A read of the physical register being written in the same cycle returns the write data.
- R12: The pointer wraps: a save from 0 gives 7, and a restore from 7 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_idx | input | 5 | Architectural index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 5 | Architectural index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index, write port |
| wr_data | input | 32 | Write data |
| save_i | input | 1 | Procedure call: move to next window |
| restore_i | input | 1 | Procedure return: move to previous window |
| cwp_o | output | 3 | Current window pointer |
| overflow_o | output | 1 | Save needs a spill; pointer held |
| underflow_o | output | 1 | Restore needs a fill; pointer held |

## Verification
The bench drives the pointer across the 7-to-0 wrap in both directions. If the incoming-register mapping did not wrap, arguments passed across that boundary would be read from the wrong window or out of range. It fills the ring to exactly six resident windows and then issues one more save. An off-by-one in the count would either move the pointer into a window still owned by an ancestor or raise overflow one call early. It pairs writes with simultaneous save, restore, and same-index reads: a design that wrote through the new pointer would corrupt the callee's frame, and one without bypass would return stale data. Zero-index writes, and save with restore together, confirm that neither disturbs state.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int GRP  = 8;   // registers per group
  localparam int IDXW = 5;   // architectural index width
  localparam int OFFW = 3;   // offset within a group

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } grp_e;
endpackage

// File: rtl/wrf_rst_sync.sv
module wrf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wrf_map.sv
module wrf_map
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CWPW = $clog2(NWIN),
  parameter int PW   = $clog2(GRP + NWIN * 2 * GRP)
) (
  input  logic [CWPW-1:0] cwp,
  input  logic [IDXW-1:0] idx,
  output logic [PW-1:0]   phys
);
  grp_e            grp;
  logic [OFFW-1:0] off;
  logic [CWPW-1:0] win;
  logic [PW-1:0]   base;

  always_comb begin
    grp  = grp_e'(idx[IDXW-1:OFFW]);
    off  = idx[OFFW-1:0];
    // incoming registers live in the caller window, one step up the ring
    win  = (grp == GRP_IN) ? cwp + 1'b1 : cwp;
    base = PW'(GRP) + PW'(win) * PW'(2 * GRP);
    unique case (grp)
      GRP_GLOBAL: phys = PW'(off);
      GRP_LOCAL:  phys = base + PW'(off);
      default:    phys = base + PW'(GRP) + PW'(off);  // out and in share storage
    endcase
  end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
  parameter int NWIN = 8,
  parameter int CWPW = $clog2(NWIN),
  parameter int DEPW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_i,
  input  logic            restore_i,
  output logic [CWPW-1:0] cwp_o,
  output logic            overflow_o,
  output logic            underflow_o
);
  localparam logic [DEPW-1:0] LIMIT = DEPW'(NWIN - 2);

  logic [CWPW-1:0] cwp_q, cwp_d;
  logic [DEPW-1:0] depth_q, depth_d;
  logic            do_save, do_rest, step_en;

  always_comb begin
    do_save     = save_i & ~restore_i;
    do_rest     = restore_i & ~save_i;
    overflow_o  = do_save && (depth_q == LIMIT);
    underflow_o = do_rest && (depth_q == '0);
    step_en     = (do_save & ~overflow_o) | (do_rest & ~underflow_o);
    cwp_d       = cwp_q;
    depth_d     = depth_q;
    if (do_save && !overflow_o) begin
      cwp_d   = cwp_q - 1'b1;
      depth_d = depth_q + 1'b1;
    end else if (do_rest && !underflow_o) begin
      cwp_d   = cwp_q + 1'b1;
      depth_d = depth_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q   <= '0;
      depth_q <= '0;
    end else if (step_en) begin
      cwp_q   <= cwp_d;
      depth_q <= depth_d;
    end
  end

  assign cwp_o = cwp_q;

  // R5
  save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && !restore_i && !overflow_o) |=> cwp_q == $past(cwp_q) - 1'b1);
  // R6
  rest_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && !save_i && !underflow_o) |=> cwp_q == $past(cwp_q) + 1'b1);
  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> $stable(cwp_q) && $stable(depth_q));
  // R8
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> $stable(cwp_q));
  // R9
  both_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |=> $stable(cwp_q) && $stable(depth_q));
  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= LIMIT);
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int NPHYS = 136,
  parameter int PW    = 8,
  parameter int DW    = 32,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [PW-1:0]           wphys,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][PW-1:0]  rphys,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  logic [DW-1:0] regs [NPHYS];
  logic          wr_live;

  assign wr_live = we && (wphys != '0);

  always_ff @(posedge clk) begin
    if (wr_live) regs[wphys] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rphys[p] == '0)                  rdata[p] = '0;
      else if (wr_live && wphys == rphys[p]) rdata[p] = wdata;   // write-first
      else                                 rdata[p] = regs[rphys[p]];
    end
  end

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |=> regs[$past(wphys)] == $past(wdata));
endmodule

// File: rtl/reg_window_file.sv
module reg_window_file
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4:0]              rd_a_idx,
  output logic [DW-1:0]           rd_a_data,
  input  logic [4:0]              rd_b_idx,
  output logic [DW-1:0]           rd_b_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic                    save_i,
  input  logic                    restore_i,
  output logic [$clog2(NWIN)-1:0] cwp_o,
  output logic                    overflow_o,
  output logic                    underflow_o
);
  localparam int CWPW  = $clog2(NWIN);
  localparam int NPHYS = GRP + NWIN * 2 * GRP;
  localparam int PW    = $clog2(NPHYS);
  localparam int NRD   = 2;
  localparam int NPORT = NRD + 1;  // map slots: reads then write

  logic                    rst_sync_n;
  logic [CWPW-1:0]         cwp;
  logic [NPORT-1:0][4:0]   port_idx;
  logic [NPORT-1:0][PW-1:0] port_phys;
  logic [NRD-1:0][PW-1:0]  rphys;
  logic [NRD-1:0][DW-1:0]  rdata;

  wrf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wrf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .save_i      (save_i),
    .restore_i   (restore_i),
    .cwp_o       (cwp),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  assign port_idx = {wr_idx, rd_b_idx, rd_a_idx};

  // all ports resolve through the pointer held before any step this cycle
  for (genvar p = 0; p < NPORT; p++) begin : g_map
    wrf_map #(.NWIN(NWIN), .CWPW(CWPW), .PW(PW)) u_map (
      .cwp  (cwp),
      .idx  (port_idx[p]),
      .phys (port_phys[p])
    );
  end

  assign rphys = {port_phys[1], port_phys[0]};

  wrf_store #(.NPHYS(NPHYS), .PW(PW), .DW(DW), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (wr_en),
    .wphys (port_phys[2]),
    .wdata (wr_data),
    .rphys (rphys),
    .rdata (rdata)
  );

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];
  assign cwp_o     = cwp;

  // R3
  g0_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_a_idx == 5'd0) |-> rd_a_data == '0);
  // R1
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(overflow_o && underflow_o));
endmodule

// File: tb/reg_window_file_test.sv
module reg_window_file_test;
  localparam int NWIN  = 8;
  localparam int DW    = 32;
  localparam int NPHYS = 8 + NWIN * 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4:0]    rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic          wr_en, save_i, restore_i;
  logic [2:0]    cwp_o;
  logic          overflow_o, underflow_o;

  always #4 clk = ~clk;  // 125 MHz

  reg_window_file #(.NWIN(NWIN), .DW(DW)) uut (.*);

  logic [DW-1:0] mem_m [NPHYS];
  bit            known_m [NPHYS];
  int            cwp_m, depth_m;
  int            vectors = 0, errors = 0;

  function automatic int phys_of(int w, int idx);
    if (idx < 8)  return idx;
    if (idx < 16) return 8 + w * 16 + 8 + (idx - 8);
    if (idx < 24) return 8 + w * 16 + (idx - 16);
    return 8 + ((w + 1) % NWIN) * 16 + 8 + (idx - 24);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, int idx, logic [31:0] act);
    int p = phys_of(cwp_m, idx);
    if (p == 0) chk(tag, act, 32'h0);
    else if (wr_en && wr_idx != 0 && phys_of(cwp_m, int'(wr_idx)) == p) chk(tag, act, wr_data);
    else if (known_m[p]) chk(tag, act, mem_m[p]);
  endtask

  task automatic cycle(bit sv, bit rs, bit we, int wi, logic [31:0] wd,
                       int ra, int rb, string tag);
    bit eo, eu;
    @(negedge clk);
    save_i = sv; restore_i = rs; wr_en = we;
    wr_idx = 5'(wi); wr_data = wd; rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    #1;
    eo = sv && !rs && depth_m == NWIN - 2;
    eu = rs && !sv && depth_m == 0;
    chk("R12 pointer", 32'(cwp_o), 32'(cwp_m));
    chk("R7 overflow", 32'(overflow_o), 32'(eo));
    chk("R8 underflow", 32'(underflow_o), 32'(eu));
    rd_chk(tag, ra, rd_a_data);
    rd_chk(tag, rb, rd_b_data);
    @(posedge clk);
    if (we && wi != 0) begin
      mem_m[phys_of(cwp_m, wi)]   = wd;
      known_m[phys_of(cwp_m, wi)] = 1'b1;
    end
    if (sv && !rs && !eo) begin cwp_m = (cwp_m + NWIN - 1) % NWIN; depth_m++; end
    if (rs && !sv && !eu) begin cwp_m = (cwp_m + 1) % NWIN; depth_m--; end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    cwp_m = 0; depth_m = 0;
    rst_n = 1'b0; save_i = 0; restore_i = 0; wr_en = 0;
    wr_idx = 0; wr_data = 0; rd_a_idx = 0; rd_b_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 pointer", 32'(cwp_o), 0);
    chk("R1 flags", {30'd0, overflow_o, underflow_o}, 0);
    cycle(0, 1, 0, 0, 0, 0, 0, "R1");            // R8 underflow at depth 0
    chk("R1 no resident window", 32'(cwp_o), 0);
    // R2/R3: globals and the zero register
    for (int g = 1; g < 8; g++) cycle(0, 0, 1, g, 32'h6000_0000 + g, 0, 0, "R2");
    cycle(0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0, "R3");
    cycle(0, 0, 0, 0, 0, 0, 1, "R3 zero reads zero");
    chk("R3 g1 untouched", rd_b_data, 32'h6000_0001);
    // R4/R5/R10/R12: pass arguments across the 0->7 wrap
    cycle(0, 0, 1, 16, 32'h1111_0000, 0, 0, "R4");
    cycle(0, 0, 1, 13, 32'hA0A0_0005, 0, 0, "R5");
    cycle(1, 0, 1, 14, 32'hA1A1_0006, 0, 0, "R10");
    cycle(0, 0, 0, 0, 0, 29, 30, "R5 R10 in regs");
    chk("R12 wrap to 7", 32'(cwp_o), 7);
    chk("R5 in5 = caller out5", rd_a_data, 32'hA0A0_0005);
    chk("R10 write used old window", rd_b_data, 32'hA1A1_0006);
    cycle(0, 0, 0, 0, 0, 3, 7, "R2 globals in window 7");
    // R6: return value flows back; R4 privacy of locals
    cycle(0, 0, 1, 29, 32'hD00D_0029, 0, 0, "R6");
    cycle(0, 0, 1, 16, 32'h7777_0000, 0, 0, "R4");
    cycle(0, 1, 0, 0, 0, 0, 0, "R6");
    cycle(0, 0, 0, 0, 0, 13, 16, "R6 R4");
    chk("R12 wrap to 0", 32'(cwp_o), 0);
    chk("R6 out5 sees callee in5", rd_a_data, 32'hD00D_0029);
    chk("R4 local private", rd_b_data, 32'h1111_0000);
    // R11: write-first bypass
    cycle(0, 0, 1, 20, 32'hBEEF_0020, 20, 0, "R11");
    chk("R11 bypass", rd_a_data, 32'hBEEF_0020);
    // R7: fill to six resident windows, then one more save
    for (int s = 0; s < 6; s++) cycle(1, 0, 0, 0, 0, 0, 0, "R7");
    cycle(1, 0, 0, 0, 0, 0, 0, "R7");
    chk("R7 pointer held", 32'(cwp_o), 2);
    // R9: both together
    cycle(1, 1, 0, 0, 0, 0, 0, "R9");
    chk("R9 pointer held", 32'(cwp_o), 2);
    for (int s = 0; s < 6; s++) cycle(0, 1, 0, 0, 0, 0, 0, "R6");
    cycle(0, 1, 0, 0, 0, 0, 0, "R8");
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      cycle(r < 20, r >= 15 && r < 35, $urandom_range(0, 9) < 6,
            int'($urandom_range(0, 31)), $urandom,
            int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), "R4 R11 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule